// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns a 32-bit RISC-V instruction word into the control signals that a simple single-cycle datapath needs. It looks only at the opcode, funct3 and funct7 fields. From these fields, four equality detectors each raise a match line, one for each supported instruction: addi, add, sub and lw. A lowest-number-first priority encoder reduces those lines to a compact instruction number. That number indexes a small constant control table.

The block is purely combinational. Its outputs are the instruction number, a flag that says whether any detector matched, and a 6-bit packed control word. The same control word is also driven as separate lines: register write enable, ALU operation, ALU B-source select and memory-to-register select. When nothing matches, every control output is driven to zero, so an unknown instruction never writes the register file.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: A word with opcode (bits 6:0) 0010011 and funct3 (bits 14:12) 000 is recognised as addi whatever funct7 holds. It gives number 0, valid 1 and control word 6'b010001.
- R2: Opcode 0110011, funct3 000 and funct7 (bits 31:25) 0000000 is recognised as add. It gives number 1, valid 1 and control word 6'b010000.
- R3: Opcode 0110011, funct3 000 and funct7 0100000 is recognised as sub. It gives number 2, valid 1 and control word 6'b010010.
- R4: Opcode 0000011 with funct3 010 is recognised as lw. It gives number 3, valid 1 and control word 6'b110001.
- R5: A word that no detector matches drives valid 0, number 0 and an all-zero control word. Examples are a wrong funct3, an unlisted funct7 or another opcode.
- R6: The control word layout is as follows. Bit 0 is the ALU B-source (1 = immediate). Bits 3:1 are the ALU operation (000 add, 001 subtract). Bit 4 is the register write enable. Bit 5 is memory-to-register. The separate output lines always equal these fields.
- R7: Instruction word 0x00B50633 gives number 1, write enable 1, ALU operation 000 and B-source 0.
- R8: Bits 24:15 and 11:7 (the register fields) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word to decode |
| insn_valid | output | 1 | 1 when one of the detectors matches |
| insn_num | output | 3 | Instruction number (0 addi, 1 add, 2 sub, 3 lw) |
| ctrl_word | output | 6 | Packed control word |
| reg_write | output | 1 | Register file write enable |
| alu_op | output | 3 | ALU operation code |
| alu_bsrc | output | 1 | ALU B operand source, 1 selects the immediate |
| mem_to_reg | output | 1 | Write-back source, 1 selects memory data |

## Verification
Each supported instruction is applied with ordinary register fields and with unusual ones. For addi, the immediate bits are set to all ones, which shows that funct7 is ignored. Near misses share all but one field with a real instruction: another funct3 under the arithmetic opcode, a multiply-style funct7, a store opcode, and byte loads. These show that every field each detector compares is needed. The register-field bits are then flipped in several patterns on every recognised instruction, which shows that only the opcode, funct3 and funct7 fields steer the control word.

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder #(
  parameter int NUM_W  = 3,
  parameter int CTRL_W = 6
) (
  input  logic [31:0]       instr_word,
  output logic              insn_valid,
  output logic [NUM_W-1:0]  insn_num,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              reg_write,
  output logic [2:0]        alu_op,
  output logic              alu_bsrc,
  output logic              mem_to_reg
);
  localparam int NDET = 4;
  localparam logic [6:0] OPC_ALU_IMM = 7'b0010011;
  localparam logic [6:0] OPC_ALU_REG = 7'b0110011;
  localparam logic [6:0] OPC_LOAD    = 7'b0000011;
  localparam logic [6:0] F7_BASE     = 7'b0000000;
  localparam logic [6:0] F7_ALT      = 7'b0100000;

  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [NDET-1:0] hit;

  assign opc = instr_word[6:0];
  assign f3  = instr_word[14:12];
  assign f7  = instr_word[31:25];

  assign hit[0] = (opc == OPC_ALU_IMM) && (f3 == 3'b000);
  assign hit[1] = (opc == OPC_ALU_REG) && (f3 == 3'b000) && (f7 == F7_BASE);
  assign hit[2] = (opc == OPC_ALU_REG) && (f3 == 3'b000) && (f7 == F7_ALT);
  assign hit[3] = (opc == OPC_LOAD)    && (f3 == 3'b010);

  function automatic logic [CTRL_W-1:0] ctrl_table(input logic [NUM_W-1:0] idx);
    case (idx)
      NUM_W'(0): ctrl_table = CTRL_W'(6'b010001);
      NUM_W'(1): ctrl_table = CTRL_W'(6'b010000);
      NUM_W'(2): ctrl_table = CTRL_W'(6'b010010);
      NUM_W'(3): ctrl_table = CTRL_W'(6'b110001);
      default:   ctrl_table = '0;
    endcase
  endfunction

  always_comb begin
    insn_num   = '0;
    insn_valid = 1'b0;
    for (int i = NDET - 1; i >= 0; i--) begin
      if (hit[i]) begin
        insn_num   = NUM_W'(i);
        insn_valid = 1'b1;
      end
    end
  end

  assign ctrl_word  = insn_valid ? ctrl_table(insn_num) : '0;
  assign alu_bsrc   = ctrl_word[0];
  assign alu_op     = ctrl_word[3:1];
  assign reg_write  = ctrl_word[4];
  assign mem_to_reg = ctrl_word[5];
endmodule

// File: rtl/insn_ctrl_decoder_chk.sv
module insn_ctrl_decoder_chk (
  input logic [31:0] instr_word,
  input logic        insn_valid,
  input logic [2:0]  insn_num,
  input logic [5:0]  ctrl_word,
  input logic        reg_write,
  input logic [2:0]  alu_op,
  input logic        alu_bsrc,
  input logic        mem_to_reg
);
  always_comb begin
    if (!$isunknown(instr_word)) begin
      if (instr_word[6:0] == 7'b0010011 && instr_word[14:12] == 3'b000)
        a_r1_addi_seen: assert (insn_valid && insn_num == 3'd0 && alu_bsrc && !mem_to_reg);
      if (instr_word[6:0] == 7'b0110011 && instr_word[14:12] == 3'b000 && instr_word[31:25] == 7'b0000000)
        a_r2_add_seen: assert (insn_valid && insn_num == 3'd1 && !alu_bsrc && alu_op == 3'b000);
      if (alu_op == 3'b001)
        a_r3_sub_only: assert (instr_word[31:25] == 7'b0100000 && instr_word[6:0] == 7'b0110011);
      if (mem_to_reg)
        a_r4_load_only: assert (instr_word[6:0] == 7'b0000011 && instr_word[14:12] == 3'b010);
      if (!insn_valid)
        a_r5_quiet: assert (ctrl_word == 6'b0 && insn_num == 3'd0 && !reg_write);
      if (insn_valid)
        a_r5_writes: assert (reg_write);
    end
  end
endmodule

bind insn_ctrl_decoder insn_ctrl_decoder_chk u_chk (.*);

// File: tb/insn_ctrl_decoder_test.sv
module insn_ctrl_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] instr_word;
  logic insn_valid, reg_write, alu_bsrc, mem_to_reg;
  logic [2:0] insn_num, alu_op;
  logic [5:0] ctrl_word;

  insn_ctrl_decoder uut (
    .instr_word(instr_word), .insn_valid(insn_valid), .insn_num(insn_num),
    .ctrl_word(ctrl_word), .reg_write(reg_write), .alu_op(alu_op),
    .alu_bsrc(alu_bsrc), .mem_to_reg(mem_to_reg)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int NV = 16;
  localparam logic [31:0] VEC_IN [NV] = '{
    32'h00100513, 32'hFFF00093, 32'h00B50633, 32'h00000033,
    32'h40B50633, 32'h0002A503, 32'h00B54633, 32'h02B50633,
    32'h40B51633, 32'h00028503, 32'h00A2A023, 32'h00151513,
    32'h00000000, 32'hFFFFFFFF, 32'h7E00A503, 32'h40000033 };
  localparam logic [9:0] VEC_EXP [NV] = '{
    10'h211, 10'h211, 10'h250, 10'h250,
    10'h292, 10'h2F1, 10'h000, 10'h000,
    10'h000, 10'h000, 10'h000, 10'h000,
    10'h000, 10'h000, 10'h2F1, 10'h292 };
  localparam string VEC_REQ [NV] = '{
    "R1", "R1", "R7", "R2", "R3", "R4", "R5", "R5",
    "R5", "R5", "R5", "R5", "R5", "R5", "R4", "R3" };

  task automatic check(input string req, input logic [9:0] exp);
    logic [9:0] got;
    got = {insn_valid, insn_num, ctrl_word};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s word=%h got=%h expected=%h", req, instr_word, got, exp);
    end
    checks++;
    if ({mem_to_reg, reg_write, alu_op, alu_bsrc} !== ctrl_word) begin
      errors++;
      $display("FAIL R6 word=%h lines=%b expected=%b", instr_word,
               {mem_to_reg, reg_write, alu_op, alu_bsrc}, ctrl_word);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr_word = w;
    @(negedge clk);
  endtask

  initial begin
    instr_word = 32'h0;
    repeat (2) @(negedge clk);
    check("R5 reset", 10'h000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC_IN[i]);
      check(VEC_REQ[i], VEC_EXP[i]);
    end

    apply(32'h00B50633);
    checks++;
    if (!(insn_num == 3'd1 && reg_write && alu_op == 3'b000 && !alu_bsrc)) begin
      errors++;
      $display("FAIL R7 got num=%0d we=%b op=%b b=%b expected num=1 we=1 op=000 b=0",
               insn_num, reg_write, alu_op, alu_bsrc);
    end

    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] base, mask;
        logic [9:0] exp;
        case (b)
          0: begin base = 32'h00000013; exp = 10'h211; end
          1: begin base = 32'h00000033; exp = 10'h250; end
          2: begin base = 32'h40000033; exp = 10'h292; end
          default: begin base = 32'h00002003; exp = 10'h2F1; end
        endcase
        case (p)
          0: mask = 32'h01FF8F80;
          1: mask = 32'h01558A80;
          2: mask = 32'h00AA8500;
          default: mask = 32'h01000080;
        endcase
        apply(base ^ mask);
        check("R8", exp);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule